// File: doc/BRIEF.md
# DRAM Page-Hit Tracker with Row-Strobe Hold

This block sits beside a DRAM controller's sequencer. It decides whether the current access to DRAM space can go ahead as a fast-page burst on the row that is already open, or needs a fresh row activation. From the same decision it produces the request that keeps the active-low row strobe asserted. The row-compare field is cut out of the access address. Its top bit comes from the address-space mode: bit 19 in the 1 MB mode, bit 23 in the 16 MB mode. Its bottom bit comes from the column-multiplex setting together with the bus width of the area.

A burst needs only a matching row, not consecutive addresses, so idle cycles between DRAM accesses do not break a burst. When burst is enabled together with the hold-through-other-spaces control, the row stays open while other address spaces are accessed. The next DRAM access then bursts if its row matches. A page miss, a change to the mode inputs, an illegal multiplex setting or a disabled burst each close the row. After a miss the strobe is released for one cycle, and then the new row is latched and reopened.

Top module: `dram_page_tracker`

## Requirements
- R1: The low bit of the compared row field is address bit 9 + mux_sel − width_8bit (mux_sel 00: bit 9 on a 16-bit area, bit 8 on an 8-bit area; 01: bits 10/9; 10: bits 11/10). width_8bit is 0 for a 16-bit area and 1 for an 8-bit area. Address bits below the low bit have no effect on page_hit.
- R2: The high bit of the compared field is address bit 19 when space_16m is 0 and bit 23 when it is 1. Bits above it have no effect on page_hit.
- R3: cfg_illegal is 1 exactly when mux_sel is 11. While it is 1, page_hit is 0 and ras_hold is 0 from the next cycle on.
- R4: After reset ras_hold is 0 and open_row is 0, and the first DRAM access reports page_hit 0.
- R5: A DRAM access (acc_valid and dram_sel) that is not a hit drives ras_hold to 0 in the next cycle. If nothing closes the row, ras_hold is 1 one cycle later, with open_row holding the masked row field: open_row bit k equals address bit k+8 when that bit is inside the field, and 0 otherwise.
- R6: page_hit is 1 for a DRAM access whose row field equals open_row while ras_hold is 1, even after idle cycles. A hit leaves ras_hold and open_row unchanged.
- R7: When burst_en and ras_down_en are both 1, an access to another space (acc_valid with dram_sel 0) keeps the row open. The next DRAM access to the same row is a hit.
- R8: When ras_down_en or burst_en is 0, an access to another space closes the row: ras_hold is 0 in the next cycle.
- R9: While burst_en is 0, page_hit is 0 and ras_hold is 0 from the next cycle on.
- R10: A change of mux_sel, width_8bit or space_16m from the previous clocked cycle forces page_hit to 0 in that cycle and closes the row in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| dram_sel | input | 1 | The access targets DRAM space |
| width_8bit | input | 1 | Area bus width: 0 = 16-bit, 1 = 8-bit |
| mux_sel | input | 2 | Column-multiplex setting (11 illegal) |
| space_16m | input | 1 | 0 = 1 MB space, 1 = 16 MB space |
| burst_en | input | 1 | Fast-page burst enable |
| ras_down_en | input | 1 | Keep row open across other-space accesses |
| page_hit | output | 1 | Current DRAM access continues the open row |
| ras_hold | output | 1 | Request to keep the row strobe asserted |
| cfg_illegal | output | 1 | Illegal multiplex setting |
| open_row | output | ADDR_W-8 | Latched masked row field (bit k = address bit k+8) |

## Verification
Wrong state in this block shows up at the ports right away. A stale row-valid bit shows as a false page_hit on the next DRAM access, in the same cycle. A wrong latched row shows on open_row one cycle after the reopen. A missing reopen or a missed close shows on ras_hold one cycle after the event that should have caused it. A wrong field bound shows as a hit or miss that flips when one address bit at the edge of the field changes. The bench drives such edge bits on purpose and compares every output on every cycle.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  typedef struct packed {
    logic [1:0] mux;
    logic       w8;
    logic       s16;
  } dpt_cfg_t;

  // lowest compared address bit, from multiplex setting and width
  function automatic int field_lo(input logic [1:0] mux, input logic w8, input int lo_base);
    return lo_base + int'(mux) - int'(w8);
  endfunction

  // highest compared address bit, from address-space mode
  function automatic int field_hi(input logic s16, input int hi_small, input int hi_large);
    return s16 ? hi_large : hi_small;
  endfunction

endpackage

// File: rtl/dpt_row_field.sv
module dpt_row_field
  import dpt_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ROW_BASE = 8,
  parameter int LO_BASE  = 9,
  parameter int HI_SMALL = 19,
  localparam int ROW_W   = ADDR_W - ROW_BASE
) (
  input  logic [ADDR_W-1:0] addr,
  input  dpt_cfg_t          cfg,
  output logic [ROW_W-1:0]  key,
  output logic              illegal
);

  logic [ROW_W-1:0] mask;
  int lo_bit;
  int hi_bit;

  always_comb begin
    lo_bit = field_lo(cfg.mux, cfg.w8, LO_BASE);
    hi_bit = field_hi(cfg.s16, HI_SMALL, ADDR_W - 1);
    for (int i = 0; i < ROW_W; i++) begin
      mask[i] = ((i + ROW_BASE) >= lo_bit) && ((i + ROW_BASE) <= hi_bit);
    end
  end

  assign key     = addr[ADDR_W-1:ROW_BASE] & mask;
  assign illegal = (cfg.mux == 2'b11);

endmodule

// File: rtl/dpt_cfg_watch.sv
module dpt_cfg_watch
  import dpt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dpt_cfg_t cfg,
  output logic     changed
);

  dpt_cfg_t cfg_q;
  logic     known_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      known_q <= 1'b0;
    end else begin
      cfg_q   <= cfg;
      known_q <= 1'b1;
    end
  end

  assign changed = known_q && (cfg != cfg_q);

endmodule

// File: rtl/dpt_row_state.sv
module dpt_row_state #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             acc_dram,
  input  logic             acc_other,
  input  logic             ras_down,
  input  logic             hit,
  input  logic [ROW_W-1:0] key,
  output logic             row_open,
  output logic             pend,
  output logic [ROW_W-1:0] row_q
);

  logic [ROW_W-1:0] pend_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      pend     <= 1'b0;
      row_q    <= '0;
      pend_row <= '0;
    end else if (kill) begin
      row_open <= 1'b0;
      pend     <= 1'b0;
    end else if (acc_dram) begin
      if (!hit) begin
        row_open <= 1'b0;
        pend     <= 1'b1;
        pend_row <= key;
      end
    end else if (acc_other && !ras_down) begin
      row_open <= 1'b0;
      pend     <= 1'b0;
    end else if (pend) begin
      row_open <= 1'b1;
      row_q    <= pend_row;
      pend     <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_page_tracker.sv
module dram_page_tracker
  import dpt_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int ROW_BASE = 8,
  parameter int LO_BASE  = 9,
  parameter int HI_SMALL = 19,
  localparam int ROW_W   = ADDR_W - ROW_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              dram_sel,
  input  logic              width_8bit,
  input  logic [1:0]        mux_sel,
  input  logic              space_16m,
  input  logic              burst_en,
  input  logic              ras_down_en,
  output logic              page_hit,
  output logic              ras_hold,
  output logic              cfg_illegal,
  output logic [ROW_W-1:0]  open_row
);

  dpt_cfg_t         cfg;
  logic [ROW_W-1:0] key;
  logic             illegal;
  logic             cfg_change;
  logic             acc_dram;
  logic             acc_other;
  logic             ras_down;
  logic             kill;
  logic             row_open;
  logic             pend;
  logic [ROW_W-1:0] row_q;

  assign cfg = '{mux: mux_sel, w8: width_8bit, s16: space_16m};

  dpt_row_field #(
    .ADDR_W(ADDR_W), .ROW_BASE(ROW_BASE), .LO_BASE(LO_BASE), .HI_SMALL(HI_SMALL)
  ) field_i (
    .addr(acc_addr), .cfg(cfg), .key(key), .illegal(illegal)
  );

  dpt_cfg_watch watch_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .changed(cfg_change)
  );

  assign acc_dram  = acc_valid && dram_sel;
  assign acc_other = acc_valid && !dram_sel;
  assign ras_down  = burst_en && ras_down_en;
  assign kill      = illegal || !burst_en || cfg_change;

  assign page_hit = acc_dram && row_open && !kill && (key == row_q);

  dpt_row_state #(.ROW_W(ROW_W)) state_i (
    .clk(clk), .rst_n(rst_n), .kill(kill), .acc_dram(acc_dram),
    .acc_other(acc_other), .ras_down(ras_down), .hit(page_hit), .key(key),
    .row_open(row_open), .pend(pend), .row_q(row_q)
  );

  assign ras_hold    = row_open;
  assign cfg_illegal = illegal;
  assign open_row    = row_q;

endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
  parameter int ROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_dram,
  input logic             acc_other,
  input logic             ras_down,
  input logic             kill,
  input logic             pend,
  input logic             burst_en,
  input logic             page_hit,
  input logic             cfg_illegal,
  input logic             ras_hold,
  input logic [ROW_W-1:0] open_row
);

  p_illegal_nohit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> !page_hit);

  p_closed_nohit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_hold |-> !page_hit);

  p_miss_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_dram && !page_hit) |=> !ras_hold);

  p_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !kill && !acc_dram && !(acc_other && !ras_down)) |=> ras_hold);

  p_hit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    page_hit |=> (ras_hold && $stable(open_row)));

  p_rasdown_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_hold && acc_other && ras_down && !kill) |=> ras_hold);

  p_other_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_other && !ras_down) |=> !ras_hold);

  p_burst_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |=> !ras_hold);

  p_kill_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !ras_hold);

endmodule

bind dram_page_tracker dpt_checker #(.ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_dram(acc_dram), .acc_other(acc_other),
  .ras_down(ras_down), .kill(kill), .pend(pend), .burst_en(burst_en),
  .page_hit(page_hit), .cfg_illegal(cfg_illegal), .ras_hold(ras_hold),
  .open_row(open_row)
);

// File: tb/dram_page_tracker_tb.sv
module dram_page_tracker_tb_top;

  localparam int AW = 24;
  localparam int RW = AW - 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          dram_sel = 1'b0;
  logic          width_8bit = 1'b0;
  logic [1:0]    mux_sel = 2'b00;
  logic          space_16m = 1'b0;
  logic          burst_en = 1'b1;
  logic          ras_down_en = 1'b1;
  logic          page_hit, ras_hold, cfg_illegal;
  logic [RW-1:0] open_row;

  int tests = 0;
  int fails = 0;

  // reference state
  logic          m_open = 1'b0;
  logic          m_pend = 1'b0;
  logic [RW-1:0] m_row = '0;
  logic [RW-1:0] m_prow = '0;
  logic [3:0]    m_cfg = '0;
  logic          m_known = 1'b0;

  always #4 clk = ~clk;

  dram_page_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .dram_sel(dram_sel), .width_8bit(width_8bit), .mux_sel(mux_sel),
    .space_16m(space_16m), .burst_en(burst_en), .ras_down_en(ras_down_en),
    .page_hit(page_hit), .ras_hold(ras_hold), .cfg_illegal(cfg_illegal),
    .open_row(open_row)
  );

  // row field per R1/R2 table, written as a case on the settings
  function automatic logic [RW-1:0] ref_key(input logic [AW-1:0] a, input logic [1:0] mx,
                                            input logic w8, input logic s16);
    int lo;
    int hi;
    logic [RW-1:0] k;
    case ({mx, w8})
      3'b000: lo = 9;
      3'b001: lo = 8;
      3'b010: lo = 10;
      3'b011: lo = 9;
      3'b100: lo = 11;
      3'b101: lo = 10;
      default: lo = 12;
    endcase
    hi = s16 ? 23 : 19;
    k = '0;
    for (int b = 8; b < AW; b++) if (b >= lo && b <= hi) k[b-8] = a[b];
    return k;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: inputs already driven at negedge
  task automatic step(input string tag);
    logic ill, chg, kill, dram, other, hit, rd;
    logic [RW-1:0] k;
    ill   = (mux_sel == 2'b11);
    chg   = m_known && ({mux_sel, width_8bit, space_16m} != m_cfg);
    kill  = ill || !burst_en || chg;
    dram  = acc_valid && dram_sel;
    other = acc_valid && !dram_sel;
    rd    = burst_en && ras_down_en;
    k     = ref_key(acc_addr, mux_sel, width_8bit, space_16m);
    hit   = dram && m_open && !kill && (k == m_row);
    #1;
    chk(tag, "page_hit", 32'(page_hit), 32'(hit));
    chk(tag, "cfg_illegal", 32'(cfg_illegal), 32'(ill));
    chk(tag, "ras_hold", 32'(ras_hold), 32'(m_open));
    chk(tag, "open_row", 32'(open_row), 32'(m_row));
    @(posedge clk);
    m_cfg = {mux_sel, width_8bit, space_16m};
    m_known = 1'b1;
    if (kill) begin
      m_open = 1'b0; m_pend = 1'b0;
    end else if (dram) begin
      if (!hit) begin m_open = 1'b0; m_pend = 1'b1; m_prow = k; end
    end else if (other && !rd) begin
      m_open = 1'b0; m_pend = 1'b0;
    end else if (m_pend) begin
      m_open = 1'b1; m_row = m_prow; m_pend = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic drv(input logic v, input logic d, input logic [AW-1:0] a, input string tag);
    acc_valid = v; dram_sel = d; acc_addr = a;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4: reset state and first access
    drv(0, 0, 24'h0, "R4");
    drv(1, 1, 24'h012345, "R4");
    drv(0, 0, 24'h0, "R5");
    drv(0, 0, 24'h0, "R5");
    // R1: bit 8 outside field for 16-bit mux 00; bit 9 inside
    drv(1, 1, 24'h0122FF, "R1");
    drv(1, 1, 24'h012145, "R1");
    drv(0, 0, 24'h0, "R5");
    drv(0, 0, 24'h0, "R5");
    // R6: idle gap then same row
    drv(0, 0, 24'h0, "R6");
    drv(1, 1, 24'h012000, "R6");
    // R2: bits above 19 ignored in 1 MB mode
    drv(1, 1, 24'hF12000, "R2");
    // R10: switch to 16 MB mode
    space_16m = 1'b1;
    drv(1, 1, 24'hF12000, "R10");
    drv(0, 0, 24'h0, "R10");
    drv(0, 0, 24'h0, "R5");
    drv(1, 1, 24'h012000, "R2");
    drv(0, 0, 24'h0, "R5");
    drv(0, 0, 24'h0, "R5");
    // R7: other-space access with hold enabled
    drv(1, 0, 24'h300000, "R7");
    drv(1, 1, 24'h0121FF, "R7");
    // R8: hold disabled closes row
    ras_down_en = 1'b0;
    drv(1, 0, 24'h300000, "R8");
    drv(1, 1, 24'h0121FF, "R8");
    drv(0, 0, 24'h0, "R8");
    drv(0, 0, 24'h0, "R8");
    ras_down_en = 1'b1;
    // R3: illegal multiplex
    mux_sel = 2'b11;
    drv(1, 1, 24'h012000, "R3");
    drv(1, 1, 24'h012000, "R3");
    mux_sel = 2'b10; width_8bit = 1'b1;
    drv(1, 1, 24'h012000, "R1");
    drv(0, 0, 24'h0, "R1");
    drv(0, 0, 24'h0, "R1");
    drv(1, 1, 24'h0123FF, "R1");
    drv(1, 1, 24'h012400, "R1");
    // R9: burst disabled
    burst_en = 1'b0;
    drv(1, 1, 24'h012400, "R9");
    drv(1, 1, 24'h012400, "R9");
    burst_en = 1'b1;
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] pool;
      int r;
      r = int'($urandom % 4);
      pool = (r == 0) ? 24'h012000 : (r == 1) ? 24'h0A4800 : (r == 2) ? 24'h812000 : 24'h5FF000;
      if ($urandom % 40 == 0) mux_sel = 2'($urandom);
      if ($urandom % 40 == 0) width_8bit = 1'($urandom);
      if ($urandom % 60 == 0) space_16m = 1'($urandom);
      if ($urandom % 50 == 0) burst_en = ($urandom % 4 != 0);
      if ($urandom % 30 == 0) ras_down_en = 1'($urandom);
      drv(($urandom % 4) != 0, ($urandom % 3) != 0, pool ^ AW'($urandom & 32'h00000FFF),
          "R6");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule